// File: doc/BRIEF.md
# Page Access Permission Evaluator

This block decides whether a load, a store or an instruction fetch may touch a page that has already been translated. It combines three independent permission sources. The first is a protection table indexed by the page's three-bit protection code and an effective key. The second is execute suppression from the page's no-execute and guarded bits. The third is a pair of 64-bit per-key mask registers, one for data and one for fetch, with one two-bit field selected by the page's five-bit storage key.

The result is a read/write/execute permission triple, a grant flag for the requested access type, and fault-reason bits that say which source refused the access. Inputs are sampled on a clock edge and the result is registered, so the outputs appear one cycle after the request. The translation pipeline holds its request for a cycle and routes the reasons to its own exception logic.

Top module: `perm_eval`

## Requirements
- R1: While `rst` is high, every output reads 0 after the next rising clock edge.
- R2: The outputs are registered. After each rising edge with `rst` low, they show the evaluation of the inputs sampled at that edge.
- R3: The effective key is `seg_key_prob` when `prob_state` is 1, and `seg_key_sup` when `prob_state` is 0.
- R4: With effective key 0, `pp_code` values 0, 1 and 2 allow read, write and execute. Values 3 and 6 allow read and execute. Values 4, 5 and 7 allow nothing.
- R5: With effective key 1, `pp_code` value 2 allows read, write and execute. Values 1 and 3 allow read and execute. Values 0, 4, 5, 6 and 7 allow nothing.
- R6: When `no_exec` or `guarded` is 1, execute permission is removed. Read and write permission are unaffected.
- R7: When `key_prot_en` is 1, the data mask field for key k starts at bit 2*(31-k) and is two bits wide. Its upper bit removes write permission and its lower bit removes read permission. When `key_prot_en` is 0, the data mask has no effect.
- R8: The fetch mask uses the same field position. Its lower bit removes execute permission, but only when both `key_prot_en` and `fetch_mask_en` are 1. Its upper bit never has an effect.
- R9: `acc_type` is encoded as 0 for load (needs read), 1 for store (needs write) and 2 for fetch (needs execute). Code 3 is treated as a load. `granted` is 1 exactly when the required permission is present in `perm_rwx` (bit 2 read, bit 1 write, bit 0 execute).
- R10: On a denied fetch, the reasons are set as follows. `flt_nx_guard` is set if `no_exec` or `guarded` removed execute. Otherwise `flt_table` is set if the protection table denied execute. Independently, `flt_keymask` is set if the fetch mask removed execute. `flt_store` is 0.
- R11: On a denied load or store, `flt_table` is set if the table lacks the required permission, and `flt_keymask` is set if the data mask removed it. The two are set independently. `flt_store` is 1 for a store. `flt_nx_guard` is 0.
- R12: When `granted` is 1, all four fault bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_type | input | 2 | Requested access: 0 load, 1 store, 2 fetch, 3 treated as load |
| pp_code | input | 3 | Page protection code |
| no_exec | input | 1 | Page no-execute bit |
| guarded | input | 1 | Page guarded bit |
| page_key | input | 5 | Page storage key selecting a mask field |
| seg_key_prob | input | 1 | Segment key used in problem state |
| seg_key_sup | input | 1 | Segment key used in supervisor state |
| prob_state | input | 1 | 1 when the access runs in problem state |
| key_prot_en | input | 1 | Enables both key masks |
| fetch_mask_en | input | 1 | Enables the fetch mask (newer-MMU mode) |
| data_mask | input | 64 | Per-key data access mask |
| fetch_mask | input | 64 | Per-key fetch mask |
| perm_rwx | output | 3 | Combined permission: bit 2 read, bit 1 write, bit 0 execute |
| granted | output | 1 | Requested access allowed |
| flt_nx_guard | output | 1 | Denied fetch caused by no-execute or guarded |
| flt_table | output | 1 | Denial caused by the protection table |
| flt_keymask | output | 1 | Denial caused by a key mask |
| flt_store | output | 1 | Denied access was a store |

## Verification
On every cycle, the assertions check the relations that need only the previous cycle's inputs. These are: execute suppression by no-execute or guarded, write and read removal by the selected data mask field, the absence of fault bits on a grant, the single-cause rule for fetch reasons, the presence of the required permission whenever access is granted, and the clearing of outputs in reset. The exact table contents for each key and code, the key selection by privilege state, and the independent reporting of table and mask causes on data accesses can only be shown by the bench. It does this by comparing whole results against its own model, across directed sweeps and random vectors.

// File: rtl/perm_pkg.sv
package perm_pkg;

    // permission triple bit positions
    localparam int P_R = 2;
    localparam int P_W = 1;
    localparam int P_X = 0;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_t;

    typedef struct packed {
        logic nx_guard;
        logic table_deny;
        logic keymask;
        logic store;
    } fault_t;

    // protection table: key selects one of two rows
    function automatic logic [2:0] pp_lookup(input logic key, input logic [2:0] code);
        logic [2:0] p;
        p = 3'b000;
        if (!key) begin
            case (code)
                3'd0, 3'd1, 3'd2: p = 3'b111;
                3'd3, 3'd6:       p = 3'b101;
                default:          p = 3'b000;
            endcase
        end else begin
            case (code)
                3'd2:       p = 3'b111;
                3'd1, 3'd3: p = 3'b101;
                default:    p = 3'b000;
            endcase
        end
        return p;
    endfunction

    function automatic logic [2:0] need_for(input acc_t a);
        logic [2:0] n;
        case (a)
            ACC_STORE: n = 3'b010;
            ACC_FETCH: n = 3'b001;
            default:   n = 3'b100;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/perm_table_stage.sv
module perm_table_stage
    import perm_pkg::*;
(
    input  logic       prob_state,
    input  logic       seg_key_prob,
    input  logic       seg_key_sup,
    input  logic [2:0] pp_code,
    output logic [2:0] table_rwx
);
    logic eff_key;

    always_comb begin
        eff_key   = prob_state ? seg_key_prob : seg_key_sup;
        table_rwx = pp_lookup(eff_key, pp_code);
    end
endmodule

// File: rtl/perm_keymask.sv
module perm_keymask
    import perm_pkg::*;
#(
    parameter int NUM_KEYS = 32,
    localparam int KEY_W  = $clog2(NUM_KEYS),
    localparam int MASK_W = 2 * NUM_KEYS
) (
    input  logic [KEY_W-1:0]  key,
    input  logic [MASK_W-1:0] data_mask,
    input  logic [MASK_W-1:0] fetch_mask,
    input  logic              key_prot_en,
    input  logic              fetch_mask_en,
    output logic [2:0]        key_rwx
);
    logic [1:0] d_field [NUM_KEYS];
    logic [1:0] f_field [NUM_KEYS];

    // key k owns the field starting at 2*(NUM_KEYS-1-k)
    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_field
        localparam int LSB = 2 * (NUM_KEYS - 1 - k);
        assign d_field[k] = data_mask[LSB +: 2];
        assign f_field[k] = fetch_mask[LSB +: 2];
    end

    logic [1:0] d_sel, f_sel;

    always_comb begin
        d_sel = d_field[key];
        f_sel = f_field[key];
        key_rwx = 3'b111;
        if (key_prot_en) begin
            if (d_sel[1]) key_rwx[P_W] = 1'b0;
            if (d_sel[0]) key_rwx[P_R] = 1'b0;
            if (fetch_mask_en && f_sel[0]) key_rwx[P_X] = 1'b0;
        end
    end
endmodule

// File: rtl/perm_fault_enc.sv
module perm_fault_enc
    import perm_pkg::*;
(
    input  acc_t       acc,
    input  logic [2:0] table_rwx,
    input  logic [2:0] key_rwx,
    input  logic       x_suppress,
    output logic [2:0] perm_rwx,
    output logic       granted,
    output fault_t     fault
);
    logic [2:0] need;
    logic [2:0] nx_rwx;

    always_comb begin
        nx_rwx   = {2'b11, ~x_suppress};
        perm_rwx = table_rwx & key_rwx & nx_rwx;
        need     = need_for(acc);
        granted  = ((need & ~perm_rwx) == 3'b000);
        fault    = '0;
        if (!granted) begin
            if (acc == ACC_FETCH) begin
                if (x_suppress)             fault.nx_guard   = 1'b1;
                else if (!table_rwx[P_X])   fault.table_deny = 1'b1;
                fault.keymask = ~key_rwx[P_X];
            end else begin
                fault.table_deny = |(need & ~table_rwx);
                fault.keymask    = |(need & ~key_rwx);
                fault.store      = (acc == ACC_STORE);
            end
        end
    end
endmodule

// File: rtl/perm_eval.sv
module perm_eval
    import perm_pkg::*;
#(
    parameter int NUM_KEYS = 32,
    localparam int KEY_W  = $clog2(NUM_KEYS),
    localparam int MASK_W = 2 * NUM_KEYS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        acc_type,
    input  logic [2:0]        pp_code,
    input  logic              no_exec,
    input  logic              guarded,
    input  logic [KEY_W-1:0]  page_key,
    input  logic              seg_key_prob,
    input  logic              seg_key_sup,
    input  logic              prob_state,
    input  logic              key_prot_en,
    input  logic              fetch_mask_en,
    input  logic [MASK_W-1:0] data_mask,
    input  logic [MASK_W-1:0] fetch_mask,
    output logic [2:0]        perm_rwx,
    output logic              granted,
    output logic              flt_nx_guard,
    output logic              flt_table,
    output logic              flt_keymask,
    output logic              flt_store
);
    logic [2:0] table_rwx, key_rwx, comb_rwx;
    logic       comb_grant;
    fault_t     comb_fault;

    perm_table_stage u_table (
        .prob_state   (prob_state),
        .seg_key_prob (seg_key_prob),
        .seg_key_sup  (seg_key_sup),
        .pp_code      (pp_code),
        .table_rwx    (table_rwx)
    );

    perm_keymask #(.NUM_KEYS(NUM_KEYS)) u_keymask (
        .key           (page_key),
        .data_mask     (data_mask),
        .fetch_mask    (fetch_mask),
        .key_prot_en   (key_prot_en),
        .fetch_mask_en (fetch_mask_en),
        .key_rwx       (key_rwx)
    );

    perm_fault_enc u_fault (
        .acc        (acc_t'(acc_type)),
        .table_rwx  (table_rwx),
        .key_rwx    (key_rwx),
        .x_suppress (no_exec | guarded),
        .perm_rwx   (comb_rwx),
        .granted    (comb_grant),
        .fault      (comb_fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            perm_rwx     <= '0;
            granted      <= 1'b0;
            flt_nx_guard <= 1'b0;
            flt_table    <= 1'b0;
            flt_keymask  <= 1'b0;
            flt_store    <= 1'b0;
        end else begin
            perm_rwx     <= comb_rwx;
            granted      <= comb_grant;
            flt_nx_guard <= comb_fault.nx_guard;
            flt_table    <= comb_fault.table_deny;
            flt_keymask  <= comb_fault.keymask;
            flt_store    <= comb_fault.store;
        end
    end
endmodule

// File: rtl/perm_eval_chk.sv
module perm_eval_chk #(
    parameter int NUM_KEYS = 32,
    localparam int KEY_W  = $clog2(NUM_KEYS),
    localparam int MASK_W = 2 * NUM_KEYS
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        acc_type,
    input logic [2:0]        pp_code,
    input logic              no_exec,
    input logic              guarded,
    input logic [KEY_W-1:0]  page_key,
    input logic              seg_key_prob,
    input logic              seg_key_sup,
    input logic              prob_state,
    input logic              key_prot_en,
    input logic              fetch_mask_en,
    input logic [MASK_W-1:0] data_mask,
    input logic [MASK_W-1:0] fetch_mask,
    input logic [2:0]        perm_rwx,
    input logic              granted,
    input logic              flt_nx_guard,
    input logic              flt_table,
    input logic              flt_keymask,
    input logic              flt_store
);
    logic live;
    always_ff @(posedge clk) live <= !rst;

    logic [KEY_W:0] lsb_idx;
    logic wr_masked, rd_masked;
    always_comb begin
        lsb_idx   = (KEY_W+1)'(2 * (NUM_KEYS - 1 - int'(page_key)));
        rd_masked = key_prot_en && data_mask[lsb_idx];
        wr_masked = key_prot_en && data_mask[lsb_idx + 1'b1];
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (perm_rwx == 3'b000 && !granted && !flt_nx_guard && !flt_table
                 && !flt_keymask && !flt_store));

    a_r6_nx_removes_exec: assert property (@(posedge clk) disable iff (rst || !live)
        $past(no_exec || guarded) |-> !perm_rwx[0]);

    a_r7_data_mask_write: assert property (@(posedge clk) disable iff (rst || !live)
        $past(wr_masked) |-> !perm_rwx[1]);

    a_r7_data_mask_read: assert property (@(posedge clk) disable iff (rst || !live)
        $past(rd_masked) |-> !perm_rwx[2]);

    a_r12_grant_no_fault: assert property (@(posedge clk) disable iff (rst || !live)
        granted |-> !(flt_nx_guard || flt_table || flt_keymask || flt_store));

    a_r10_fetch_single_cause: assert property (@(posedge clk) disable iff (rst || !live)
        (!granted && $past(acc_type) == 2'd2) |->
            ((flt_nx_guard || flt_table || flt_keymask) && !(flt_nx_guard && flt_table) && !flt_store));

    a_r9_store_grant_needs_w: assert property (@(posedge clk) disable iff (rst || !live)
        (granted && $past(acc_type) == 2'd1) |-> perm_rwx[1]);

    a_r9_fetch_grant_needs_x: assert property (@(posedge clk) disable iff (rst || !live)
        (granted && $past(acc_type) == 2'd2) |-> perm_rwx[0]);
endmodule

bind perm_eval perm_eval_chk #(.NUM_KEYS(NUM_KEYS)) u_chk (.*);

// File: tb/tb_perm_eval.sv
module tb_perm_eval;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  acc_type;
    logic [2:0]  pp_code;
    logic        no_exec, guarded;
    logic [4:0]  page_key;
    logic        seg_key_prob, seg_key_sup, prob_state;
    logic        key_prot_en, fetch_mask_en;
    logic [63:0] data_mask, fetch_mask;
    logic [2:0]  perm_rwx;
    logic        granted, flt_nx_guard, flt_table, flt_keymask, flt_store;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    perm_eval dut (.*);

    // expected result packed as {rwx[2:0], grant, nx, table, key, store}
    function automatic logic [2:0] m_table(input logic k, input logic [2:0] c);
        logic [2:0] r;
        if (k == 1'b0) r = (c <= 3'd2) ? 3'b111 : ((c == 3'd3 || c == 3'd6) ? 3'b101 : 3'b000);
        else           r = (c == 3'd2) ? 3'b111 : ((c == 3'd1 || c == 3'd3) ? 3'b101 : 3'b000);
        return r;
    endfunction

    function automatic logic [8:0] model();
        logic k;
        logic [2:0] t, km, all, need;
        logic [1:0] df, ff;
        logic sup_x, g, nx, tb, kb, st;
        k     = prob_state ? seg_key_prob : seg_key_sup;
        t     = m_table(k, pp_code);
        df    = data_mask[62 - 2*page_key +: 2];
        ff    = fetch_mask[62 - 2*page_key +: 2];
        km    = 3'b111;
        if (key_prot_en) begin
            km[1] = ~df[1];
            km[2] = ~df[0];
            if (fetch_mask_en) km[0] = ~ff[0];
        end
        sup_x = no_exec | guarded;
        all   = t & km & {2'b11, ~sup_x};
        need  = (acc_type == 2'd1) ? 3'b010 : (acc_type == 2'd2) ? 3'b001 : 3'b100;
        g     = (all & need) == need;
        nx = 0; tb = 0; kb = 0; st = 0;
        if (!g) begin
            if (acc_type == 2'd2) begin
                nx = sup_x;
                tb = !sup_x && !t[0];
                kb = !km[0];
            end else begin
                tb = (t & need) != need;
                kb = (km & need) != need;
                st = acc_type == 2'd1;
            end
        end
        return {all, g, nx, tb, kb, st};
    endfunction

    function automatic logic [8:0] actual();
        return {perm_rwx, granted, flt_nx_guard, flt_table, flt_keymask, flt_store};
    endfunction

    task automatic check(input string tag, input logic [8:0] exp);
        n_cmp++;
        if (actual() !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b (rwx,grant,nx,table,key,store)", tag, actual(), exp);
        end
    endtask

    // drive at a falling edge, compare one full cycle later
    task automatic run(input string tag);
        logic [8:0] e;
        @(negedge clk);
        e = model();
        @(negedge clk);
        check(tag, e);
    endtask

    task automatic clear_inputs();
        acc_type = 0; pp_code = 0; no_exec = 0; guarded = 0; page_key = 0;
        seg_key_prob = 0; seg_key_sup = 0; prob_state = 0;
        key_prot_en = 0; fetch_mask_en = 0; data_mask = '0; fetch_mask = '0;
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        clear_inputs();
        acc_type = 2'd2; pp_code = 3'd2;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset", 9'b0);
        rst = 1'b0;

        // R4 / R5: sweep table for both keys and all access types
        for (int k = 0; k < 2; k++)
            for (int c = 0; c < 8; c++)
                for (int a = 0; a < 3; a++) begin
                    @(negedge clk);
                    clear_inputs();
                    seg_key_sup = k[0]; pp_code = c[2:0]; acc_type = a[1:0];
                    run(k == 0 ? "R4 key0 table" : "R5 key1 table");
                end

        // R3: problem state picks the other key
        @(negedge clk); clear_inputs();
        prob_state = 1; seg_key_prob = 1; seg_key_sup = 0; pp_code = 3'd0; acc_type = 0;
        run("R3 problem key");
        @(negedge clk); prob_state = 0; run("R3 supervisor key");

        // R6: guarded/no-exec on a writable page
        @(negedge clk); clear_inputs(); guarded = 1; pp_code = 3'd2; acc_type = 1;
        run("R6 guarded store");
        @(negedge clk); acc_type = 2; run("R6 R10 guarded fetch");
        @(negedge clk); guarded = 0; no_exec = 1; pp_code = 3'd4; run("R10 nx over table");

        // R7: data mask on key 0 (bits 63:62) and key 31 (bits 1:0)
        @(negedge clk); clear_inputs(); key_prot_en = 1; data_mask[63] = 1; acc_type = 1;
        run("R7 R11 key0 write mask");
        @(negedge clk); acc_type = 0; run("R7 key0 read ok");
        @(negedge clk); page_key = 31; data_mask = 64'h1; run("R7 key31 read mask");
        @(negedge clk); key_prot_en = 0; run("R7 disabled");

        // R8: fetch mask gating
        @(negedge clk); clear_inputs(); key_prot_en = 1; page_key = 5;
        fetch_mask[52] = 1; acc_type = 2; run("R8 mode off");
        @(negedge clk); fetch_mask_en = 1; run("R8 R10 fetch masked");
        @(negedge clk); fetch_mask = 64'h0; fetch_mask[53] = 1; run("R8 upper bit ignored");

        // R11: table and mask causes together on a store
        @(negedge clk); clear_inputs(); key_prot_en = 1; seg_key_sup = 1; pp_code = 3'd3;
        page_key = 7; data_mask[49] = 1; acc_type = 1; run("R11 both causes");
        @(negedge clk); acc_type = 3; data_mask = '0; pp_code = 3'd0; run("R9 code3 as load");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            acc_type = 2'($urandom); pp_code = 3'($urandom);
            no_exec = ($urandom % 5) == 0; guarded = ($urandom % 5) == 0;
            page_key = 5'($urandom);
            seg_key_prob = 1'($urandom); seg_key_sup = 1'($urandom); prob_state = 1'($urandom);
            key_prot_en = 1'($urandom); fetch_mask_en = 1'($urandom);
            data_mask = {$urandom, $urandom} & {$urandom, $urandom};
            fetch_mask = {$urandom, $urandom} & {$urandom, $urandom};
            run("R2 R9 R10 R11 R12 random");
        end

        // R1 again mid-run
        @(negedge clk); rst = 1; @(negedge clk);
        check("R1 reset mid-run", 9'b0);
        rst = 0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule